// File: doc/BRIEF.md
# Real-time clock interrupt status and enable register set

This block sits between the timekeeping core of a real-time clock and the system interrupt controller. Two interrupt sources feed it: a once-per-second tick event and an alarm-match event. Each arrives as a single-cycle strobe. Each strobe sets a sticky status bit. Software polls and acknowledges these bits through a small memory-mapped register window on a simple single-cycle register bus. Two further registers control whether each source drives its own interrupt line. One register turns sources on by writing ones. The other turns them off by writing ones. The resulting per-source enable state can be read back from a read-only mask register.

Each source is handled by its own four-state machine. The state encodes the pair (status, enable):

- `SRC_QUIET`: status clear, source disabled.
- `SRC_ARMED`: status clear, source enabled.
- `SRC_HELD`: status set but masked.
- `SRC_FIRING`: status set and enabled; the interrupt line is high.

The machine moves between these states as follows:

- An event strobe moves QUIET to HELD and ARMED to FIRING.
- A status acknowledge moves HELD to QUIET and FIRING to ARMED.
- An enable write moves QUIET to ARMED and HELD to FIRING.
- A disable write moves ARMED to QUIET and FIRING to HELD.
- Any combination not listed keeps the current state.

When an event and an acknowledge reach the same source in one cycle, the event wins. Register reads are combinational, so read data is valid in the same cycle as the select.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: After reset, both status bits and both enable bits are 0 and both interrupt outputs are low.
- R2: A strobe on `sec_evt` sets status bit 0 and a strobe on `alm_evt` sets status bit 1 at the next clock edge, whether or not the source is enabled. Status is read at offset 0x20.
- R3: Writing to offset 0x20 clears each status bit written as 1 and leaves each bit written as 0 unchanged.
- R4: Writing to offset 0x28 enables each source whose bit (bit 0 seconds, bit 1 alarm) is 1; bits written as 0 leave the enable state unchanged.
- R5: Writing to offset 0x2C disables each source whose bit is 1; bits written as 0 leave the enable state unchanged.
- R6: A read of offset 0x24 returns the enable state in bits 1:0 (bit 0 seconds, bit 1 alarm) and zeros above.
- R7: `sec_irq` is high exactly while status bit 0 and enable bit 0 are both set, and `alm_irq` likewise for bit 1. Each output is registered state, changing one edge after its cause.
- R8: When an event and a status write of 1 hit the same bit in one cycle, the bit is set after that edge.
- R9: Reads of offsets 0x28, 0x2C and any unmapped offset return zero. Writes to 0x24 or unmapped offsets change no state.
- R10: A write with `bus_sel` low changes no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_evt | input | 1 | One-cycle seconds event strobe |
| alm_evt | input | 1 | One-cycle alarm event strobe |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| sec_irq | output | 1 | Seconds interrupt line |
| alm_irq | output | 1 | Alarm interrupt line |

## Verification
A wrong state in one source machine shows at the ports at once: the status or mask read returns the wrong bit in the same cycle, and the matching interrupt line is wrong at the same time. A mistaken transition therefore surfaces one clock edge after the event or write that caused it.

The sweep does the following:

- It drives every combination of the two source states.
- It applies each register operation and event pattern with all four two-bit data values.
- It reads back status, mask and both lines after every step.

A misrouted bit, a lost event, or an acknowledge beating an event is caught within one step.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
    localparam int SRC_N   = 2;
    localparam int SEC_IDX = 0;
    localparam int ALM_IDX = 1;

    localparam logic [7:0] DEF_STS_OFF  = 8'h20;
    localparam logic [7:0] DEF_MASK_OFF = 8'h24;
    localparam logic [7:0] DEF_EN_OFF   = 8'h28;
    localparam logic [7:0] DEF_DIS_OFF  = 8'h2C;

    // State encoding is {status, enable}
    typedef enum logic [1:0] {
        SRC_QUIET  = 2'b00,
        SRC_ARMED  = 2'b01,
        SRC_HELD   = 2'b10,
        SRC_FIRING = 2'b11
    } src_state_e;

    typedef struct packed {
        logic wr_sts;
        logic wr_en;
        logic wr_dis;
        logic rd_sts;
        logic rd_mask;
    } bus_hit_t;
endpackage

// File: rtl/rtc_irq_decode.sv
module rtc_irq_decode
    import rtc_irq_pkg::*;
#(
    parameter int          ADDR_W   = 8,
    parameter logic [7:0]  STS_OFF  = DEF_STS_OFF,
    parameter logic [7:0]  MASK_OFF = DEF_MASK_OFF,
    parameter logic [7:0]  EN_OFF   = DEF_EN_OFF,
    parameter logic [7:0]  DIS_OFF  = DEF_DIS_OFF
) (
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output bus_hit_t          hit
);
    localparam logic [ADDR_W-1:0] A_STS  = ADDR_W'(STS_OFF);
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(MASK_OFF);
    localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(EN_OFF);
    localparam logic [ADDR_W-1:0] A_DIS  = ADDR_W'(DIS_OFF);

    logic do_wr;
    logic do_rd;

    always_comb begin
        do_wr       = sel && wr;
        do_rd       = sel && !wr;
        hit.wr_sts  = do_wr && (addr == A_STS);
        hit.wr_en   = do_wr && (addr == A_EN);
        hit.wr_dis  = do_wr && (addr == A_DIS);
        hit.rd_sts  = do_rd && (addr == A_STS);
        hit.rd_mask = do_rd && (addr == A_MASK);
    end
endmodule

// File: rtl/rtc_irq_src_fsm.sv
module rtc_irq_src_fsm
    import rtc_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic ack,
    input  logic en_set,
    input  logic en_clr,
    output logic status,
    output logic enable,
    output logic irq
);
    src_state_e state_q;
    src_state_e state_d;
    logic       stat_n;
    logic       en_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SRC_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        stat_n = 1'b0;
        en_n   = 1'b0;
        unique case (state_q)
            SRC_QUIET: begin
                stat_n = evt;
                en_n   = en_set;
            end
            SRC_ARMED: begin
                stat_n = evt;
                en_n   = en_set || !en_clr;
            end
            SRC_HELD: begin
                stat_n = evt || !ack;
                en_n   = en_set;
            end
            SRC_FIRING: begin
                stat_n = evt || !ack;
                en_n   = en_set || !en_clr;
            end
            default: begin
                stat_n = 1'b0;
                en_n   = 1'b0;
            end
        endcase
        state_d = src_state_e'({stat_n, en_n});
    end

    always_comb begin
        status = 1'b0;
        enable = 1'b0;
        irq    = 1'b0;
        unique case (state_q)
            SRC_QUIET:  ;
            SRC_ARMED:  enable = 1'b1;
            SRC_HELD:   status = 1'b1;
            SRC_FIRING: begin
                status = 1'b1;
                enable = 1'b1;
                irq    = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/rtc_irq_readmux.sv
module rtc_irq_readmux
    import rtc_irq_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  bus_hit_t          hit,
    input  logic [SRC_N-1:0]  stat,
    input  logic [SRC_N-1:0]  en,
    output logic [DATA_W-1:0] rdata
);
    always_comb begin
        rdata = '0;
        if (hit.rd_sts) begin
            rdata[SRC_N-1:0] = stat;
        end else if (hit.rd_mask) begin
            rdata[SRC_N-1:0] = en;
        end
    end
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
    import rtc_irq_pkg::*;
#(
    parameter int         ADDR_W   = 8,
    parameter int         DATA_W   = 32,
    parameter logic [7:0] STS_OFF  = DEF_STS_OFF,
    parameter logic [7:0] MASK_OFF = DEF_MASK_OFF,
    parameter logic [7:0] EN_OFF   = DEF_EN_OFF,
    parameter logic [7:0] DIS_OFF  = DEF_DIS_OFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_evt,
    input  logic              alm_evt,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              sec_irq,
    output logic              alm_irq
);
    bus_hit_t         hit;
    logic [SRC_N-1:0] evt_vec;
    logic [SRC_N-1:0] stat_vec;
    logic [SRC_N-1:0] en_vec;
    logic [SRC_N-1:0] irq_vec;
    logic             unused_wdata;

    assign evt_vec[SEC_IDX] = sec_evt;
    assign evt_vec[ALM_IDX] = alm_evt;
    assign unused_wdata     = ^bus_wdata[DATA_W-1:SRC_N];

    rtc_irq_decode #(
        .ADDR_W  (ADDR_W),
        .STS_OFF (STS_OFF),
        .MASK_OFF(MASK_OFF),
        .EN_OFF  (EN_OFF),
        .DIS_OFF (DIS_OFF)
    ) u_decode (
        .sel (bus_sel),
        .wr  (bus_wr),
        .addr(bus_addr),
        .hit (hit)
    );

    for (genvar i = 0; i < SRC_N; i++) begin : g_src
        rtc_irq_src_fsm u_fsm (
            .clk   (clk),
            .rst_n (rst_n),
            .evt   (evt_vec[i]),
            .ack   (hit.wr_sts && bus_wdata[i]),
            .en_set(hit.wr_en  && bus_wdata[i]),
            .en_clr(hit.wr_dis && bus_wdata[i]),
            .status(stat_vec[i]),
            .enable(en_vec[i]),
            .irq   (irq_vec[i])
        );
    end

    rtc_irq_readmux #(
        .DATA_W(DATA_W)
    ) u_rmux (
        .hit  (hit),
        .stat (stat_vec),
        .en   (en_vec),
        .rdata(bus_rdata)
    );

    assign sec_irq = irq_vec[SEC_IDX];
    assign alm_irq = irq_vec[ALM_IDX];
endmodule

// File: rtl/rtc_irq_ctrl_chk.sv
module rtc_irq_ctrl_chk
    import rtc_irq_pkg::*;
#(
    parameter int         ADDR_W   = 8,
    parameter int         DATA_W   = 32,
    parameter logic [7:0] STS_OFF  = DEF_STS_OFF,
    parameter logic [7:0] EN_OFF   = DEF_EN_OFF,
    parameter logic [7:0] DIS_OFF  = DEF_DIS_OFF
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sec_evt,
    input logic              alm_evt,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              sec_irq,
    input logic              alm_irq,
    input logic [SRC_N-1:0]  stat,
    input logic [SRC_N-1:0]  en
);
    logic w_sts;
    logic w_en;
    logic w_dis;

    assign w_sts = bus_sel && bus_wr && (bus_addr == ADDR_W'(STS_OFF));
    assign w_en  = bus_sel && bus_wr && (bus_addr == ADDR_W'(EN_OFF));
    assign w_dis = bus_sel && bus_wr && (bus_addr == ADDR_W'(DIS_OFF));

    // R2
    sec_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sec_evt |=> stat[SEC_IDX]);
    // R8
    alm_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alm_evt |=> stat[ALM_IDX]);
    // R3
    sec_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (w_sts && bus_wdata[SEC_IDX] && !sec_evt) |=> !stat[SEC_IDX]);
    // R4
    alm_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (w_en && bus_wdata[ALM_IDX]) |=> en[ALM_IDX]);
    // R5
    sec_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (w_dis && bus_wdata[SEC_IDX]) |=> !en[SEC_IDX]);
    // R7
    sec_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sec_irq |-> (stat[SEC_IDX] && en[SEC_IDX]));
    // R7
    alm_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alm_irq |-> (stat[ALM_IDX] && en[ALM_IDX]));
    // R10
    idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_sel |=> $stable(en));
endmodule

bind rtc_irq_ctrl rtc_irq_ctrl_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .STS_OFF(STS_OFF),
    .EN_OFF (EN_OFF),
    .DIS_OFF(DIS_OFF)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sec_evt  (sec_evt),
    .alm_evt  (alm_evt),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .sec_irq  (sec_irq),
    .alm_irq  (alm_irq),
    .stat     (stat_vec),
    .en       (en_vec)
);

// File: tb/rtc_irq_ctrl_bench.sv
module rtc_irq_ctrl_bench;
    localparam logic [7:0] A_STS  = 8'h20;
    localparam logic [7:0] A_MASK = 8'h24;
    localparam logic [7:0] A_EN   = 8'h28;
    localparam logic [7:0] A_DIS  = 8'h2C;
    localparam logic [7:0] A_BAD  = 8'h30;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sec_evt = 1'b0;
    logic        alm_evt = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sec_irq;
    logic        alm_irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rtc_irq_ctrl u_rtc_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .sec_evt(sec_evt), .alm_evt(alm_evt),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sec_irq(sec_irq), .alm_irq(alm_irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic sel);
        @(negedge clk);
        bus_sel = sel; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic pulse(input logic [1:0] e);
        @(negedge clk);
        sec_evt = e[0]; alm_evt = e[1];
        @(negedge clk);
        sec_evt = 1'b0; alm_evt = 1'b0;
    endtask

    task automatic expect_state(input string req, input logic [1:0] s, input logic [1:0] e);
        logic [31:0] d;
        rd(A_STS, d);
        check({req, " status"}, d, {30'd0, s});
        rd(A_MASK, d);
        check({req, " mask R6"}, d, {30'd0, e});
        check({req, " sec_irq R7"}, {31'd0, sec_irq}, {31'd0, s[0] & e[0]});
        check({req, " alm_irq R7"}, {31'd0, alm_irq}, {31'd0, s[1] & e[1]});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        // R1 reset state
        expect_state("R1", 2'b00, 2'b00);
        rst_n = 1'b1;
        expect_state("R1", 2'b00, 2'b00);

        // R9 read-zero offsets
        wr(A_EN, 32'h3, 1'b1);
        pulse(2'b11);
        rd(A_EN, d);  check("R9 en read", d, 32'd0);
        rd(A_DIS, d); check("R9 dis read", d, 32'd0);
        rd(A_BAD, d); check("R9 bad read", d, 32'd0);

        // R1 reset clears live state
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        expect_state("R1 rereset", 2'b00, 2'b00);

        for (int st = 0; st < 4; st++) begin
            for (int en = 0; en < 4; en++) begin
                for (int op = 0; op < 8; op++) begin
                    for (int dv = 0; dv < 4; dv++) begin
                        logic [1:0] s;
                        logic [1:0] e;
                        logic [1:0] x;
                        string tag;
                        s = 2'(st); e = 2'(en); x = 2'(dv);
                        wr(A_DIS, 32'h3, 1'b1);
                        wr(A_STS, 32'h3, 1'b1);
                        wr(A_EN, {30'd0, e}, 1'b1);
                        pulse(s);
                        expect_state("R2 setup", s, e);
                        unique case (op)
                            0: begin wr(A_STS, {30'd0, x} | 32'hFFF0, 1'b1); s = s & ~x; tag = "R3"; end
                            1: begin wr(A_EN, {30'd0, x}, 1'b1);  e = e | x;  tag = "R4"; end
                            2: begin wr(A_DIS, {30'd0, x}, 1'b1); e = e & ~x; tag = "R5"; end
                            3: begin pulse(x); s = s | x; tag = "R2"; end
                            4: begin
                                @(negedge clk);
                                sec_evt = x[0]; alm_evt = x[1];
                                bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = A_STS; bus_wdata = 32'h3;
                                @(negedge clk);
                                sec_evt = 1'b0; alm_evt = 1'b0;
                                bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
                                s = x; tag = "R8";
                            end
                            5: begin wr(A_MASK, {30'd0, x}, 1'b1); tag = "R9 mask wr"; end
                            6: begin wr(A_BAD, {30'd0, x}, 1'b1);  tag = "R9 bad wr"; end
                            default: begin wr(A_DIS, {30'd0, x}, 1'b0); tag = "R10"; end
                        endcase
                        expect_state(tag, s, e);
                    end
                end
            end
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule